// File: doc/BRIEF.md
# ARINC 429 Buffered Word Transmitter

This block takes 31-bit ARINC 429 words from a 16-bit host bus. Each word arrives in two load strobes. The block holds up to eight words in a queue. While transmission is enabled, it sends each queued word on a pair of logic-level line signals in return-to-zero form, and it appends a parity bit as the 32nd bit. Every timing count is in cycles of the block clock, which is the 1 MHz master clock. One rate input selects high-speed or low-speed bit timing. Another input selects odd or even parity. Both are captured when a word starts. An analog driver outside the block converts the A/B pair to bus voltages.

A ready output is high only when nothing is queued and no word is on the line. The host can use it to pace its loads. The same two strobes can be driven by the readout sequence of a receiver, lower half first, so a received word is queued while it is being read. If the enable drops partway through a word, that word still completes, and the rest of the queue is held until the enable returns.

Top module: `a429_xmit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `tx_ready` is 1, `line_a` and `line_b` are 0 and the queue is empty.
- R2: `load_first` captures the first half. A following `load_second` forms the word, which is sent in ARINC bit order (bit 1 first). The field positions are:
  - ARINC bits 1..8 come from first-half bits 7..0, in that order.
  - ARINC bits 9..13 come from first-half bits 11..15.
  - ARINC bit 30 comes from first-half bit 9, and ARINC bit 31 from first-half bit 10. First-half bit 8 is unused.
  - ARINC bits 14..29 come from second-half bits 0..15.
- R3: A `load_second` with no `load_first` since the last commit, or a `load_first` alone, adds no word.
- R4: The queue holds 8 words. A commit made while it is full is dropped, and that word is never sent.
- R5: `tx_ready` falls on the cycle after a commit. It rises on the cycle after the null half of bit 32 of the last queued word.
- R6: When the block is idle, `tx_enable` is high and a word is queued, the data half of bit 1 appears on the next cycle. Nothing is sent while `tx_enable` is low.
- R7: A one drives `line_a`=1 and `line_b`=0. A zero drives `line_a`=0 and `line_b`=1. A null drives both to 0, and both are never 1 together.
- R8: When `rate_slow` is 0, every bit is 5 data cycles followed by 5 null cycles. A gap of 40 cycles follows the null of bit 32.
- R9: When `rate_slow` is 1, the counts are 40, 40 and 320. The rate is captured when a word starts.
- R10: Bit 32 makes the count of ones across all 32 bits odd when `parity_even` is 0, and even when it is 1.
- R11: If `tx_enable` falls mid-word, the current word completes and no further word starts until `tx_enable` is high again.
- R12: With `tx_enable` held high and words queued, consecutive words start exactly 32 bit times plus one gap apart (360 cycles at high speed, 2880 at low speed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (1 MHz in service) |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 16 | Host bus half-word |
| load_first | input | 1 | One-cycle strobe that captures the first half |
| load_second | input | 1 | One-cycle strobe that captures the second half and commits the word |
| tx_enable | input | 1 | Allows words to be drained from the queue |
| rate_slow | input | 1 | 0 = high-speed timing, 1 = low-speed timing |
| parity_even | input | 1 | 0 = odd parity, 1 = even parity |
| line_a | output | 1 | A-side line level |
| line_b | output | 1 | B-side line level |
| tx_ready | output | 1 | High when the queue is empty and no word is on the line |

## Verification
A queue pointer or count that drifts shows up as a wrong, missing or repeated word. It also shows up as `tx_ready` at the wrong level right after a commit, or at the end of the last word. These symptoms appear within one word time. A fault in the phase counter or bit counter changes the data length, null length or gap length, or the bit count of a word. The bench compares those lengths for every bit and also checks the spacing between words, so such a fault is seen on the first affected bit. A fault in the field mapping or parity changes the decoded 32-bit frame, and the scoreboard reports it when that word finishes.

// File: rtl/a429_pkg.sv
package a429_pkg;

    localparam int HALF_W  = 16;
    localparam int WORD_W  = 31;
    localparam int FRAME_W = 32;

    typedef logic [HALF_W-1:0]  half_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MARK,
        PH_SPACE,
        PH_GAP
    } phase_e;

    // Place the two host halves at their ARINC bit positions (index = bit - 1).
    function automatic word_t merge_halves(half_t first, half_t second);
        word_t w;
        w = '0;
        for (int i = 0; i < 8; i++) begin
            w[7-i] = first[i];
        end
        for (int j = 0; j < 5; j++) begin
            w[8+j] = first[11+j];
        end
        for (int j = 0; j < 16; j++) begin
            w[13+j] = second[j];
        end
        w[29] = first[9];
        w[30] = first[10];
        return w;
    endfunction

    function automatic logic parity_fill(word_t w, logic even);
        return even ? (^w) : ~(^w);
    endfunction

endpackage

// File: rtl/a429_load_asm.sv
module a429_load_asm
    import a429_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  half_t host_data,
    input  logic  load_first,
    input  logic  load_second,
    output logic  commit,
    output word_t word
);
    half_t first_q;
    logic  pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            pending <= 1'b0;
        end else if (load_first) begin
            first_q <= host_data;
            pending <= 1'b1;
        end else if (load_second) begin
            pending <= 1'b0;
        end
    end

    assign commit = load_second & pending;
    assign word   = merge_halves(first_q, host_data);
endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
    parameter int WIDTH = 31,
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    fill
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_wr, do_rd;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));
    assign do_wr = push & ~full;
    assign do_rd = pop & ~empty;
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/a429_serial.sv
module a429_serial
    import a429_pkg::*;
#(
    parameter int FAST_HALF = 5,
    parameter int SLOW_HALF = 40,
    parameter int FAST_GAP  = 40,
    parameter int SLOW_GAP  = 320,
    localparam int MAX_HALF = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF,
    localparam int MAX_GAP  = (FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP,
    localparam int MAX_CNT  = (MAX_HALF > MAX_GAP) ? MAX_HALF : MAX_GAP,
    localparam int CW       = $clog2(MAX_CNT + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t word,
    input  logic  even_par,
    input  logic  slow,
    output logic  line_a,
    output logic  line_b,
    output logic  busy,
    output logic  idle,
    output logic  gap_end
);
    phase_e        phase;
    frame_t        shreg;
    logic [4:0]    bit_idx;
    logic [CW-1:0] cnt, half_lim, gap_lim;
    logic          slow_q;

    assign half_lim = slow_q ? CW'(SLOW_HALF - 1) : CW'(FAST_HALF - 1);
    assign gap_lim  = slow_q ? CW'(SLOW_GAP - 1)  : CW'(FAST_GAP - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            cnt     <= '0;
            slow_q  <= 1'b0;
        end else if (start) begin
            shreg   <= {parity_fill(word, even_par), word};
            slow_q  <= slow;
            bit_idx <= '0;
            cnt     <= '0;
            phase   <= PH_MARK;
        end else begin
            unique case (phase)
                PH_MARK: begin
                    if (cnt == half_lim) begin
                        cnt   <= '0;
                        phase <= PH_SPACE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SPACE: begin
                    if (cnt == half_lim) begin
                        cnt <= '0;
                        if (bit_idx == 5'd31) begin
                            phase <= PH_GAP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= shreg >> 1;
                            phase   <= PH_MARK;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt == gap_lim) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign line_a  = (phase == PH_MARK) &  shreg[0];
    assign line_b  = (phase == PH_MARK) & ~shreg[0];
    assign busy    = (phase == PH_MARK) | (phase == PH_SPACE);
    assign idle    = (phase == PH_IDLE);
    assign gap_end = (phase == PH_GAP) & (cnt == gap_lim);
endmodule

// File: rtl/a429_xmit.sv
module a429_xmit
    import a429_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int FAST_HALF = 5,
    parameter int SLOW_HALF = 40,
    parameter int FAST_GAP  = 40,
    parameter int SLOW_GAP  = 320,
    localparam int FILL_W   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] host_data,
    input  logic        load_first,
    input  logic        load_second,
    input  logic        tx_enable,
    input  logic        rate_slow,
    input  logic        parity_even,
    output logic        line_a,
    output logic        line_b,
    output logic        tx_ready
);
    logic              commit;
    word_t             new_word, head_word;
    logic              fifo_empty, fifo_full;
    logic [FILL_W-1:0] fill;
    logic              pop, ser_busy, ser_idle, ser_gap_end;

    a429_load_asm u_asm (
        .clk         (clk),
        .rst         (rst),
        .host_data   (host_data),
        .load_first  (load_first),
        .load_second (load_second),
        .commit      (commit),
        .word        (new_word)
    );

    a429_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (commit),
        .push_data (new_word),
        .pop       (pop),
        .head      (head_word),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .fill      (fill)
    );

    // A word may start from idle, or directly at the last gap cycle.
    assign pop = tx_enable & ~fifo_empty & (ser_idle | ser_gap_end);

    a429_serial #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF),
        .FAST_GAP  (FAST_GAP),
        .SLOW_GAP  (SLOW_GAP)
    ) u_ser (
        .clk      (clk),
        .rst      (rst),
        .start    (pop),
        .word     (head_word),
        .even_par (parity_even),
        .slow     (rate_slow),
        .line_a   (line_a),
        .line_b   (line_b),
        .busy     (ser_busy),
        .idle     (ser_idle),
        .gap_end  (ser_gap_end)
    );

    assign tx_ready = fifo_empty & ~ser_busy;
endmodule

// File: rtl/a429_xmit_chk.sv
module a429_xmit_chk #(
    parameter int DEPTH  = 8,
    parameter int FILL_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              line_a,
    input logic              line_b,
    input logic              tx_ready,
    input logic              push,
    input logic              full,
    input logic              pop,
    input logic [FILL_W-1:0] fill
);
    // R7
    lines_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(line_a && line_b));

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(fill) <= DEPTH);

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (fill == $past(fill)));

    // R5
    commit_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (fill == $past(fill) + FILL_W'(1)));

    // R5
    ready_null_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (!line_a && !line_b));

    // R8
    mark_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(line_a) |=> line_a);

    // R8
    mark_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(line_b) |=> line_b);
endmodule

bind a429_xmit a429_xmit_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .line_a   (line_a),
    .line_b   (line_b),
    .tx_ready (tx_ready),
    .push     (commit),
    .full     (fifo_full),
    .pop      (pop),
    .fill     (fill)
);

// File: tb/a429_xmit_bench.sv
`timescale 1ns/1ps
module a429_xmit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_data = '0;
    logic        load_first = 1'b0, load_second = 1'b0;
    logic        tx_enable = 1'b0, rate_slow = 1'b0, parity_even = 1'b0;
    logic        line_a, line_b, tx_ready;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] frame;
        logic        slow;
    } exp_t;
    exp_t expq[$];
    int   starts[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    a429_xmit u_a429_xmit (
        .clk (clk), .rst (rst), .host_data (host_data),
        .load_first (load_first), .load_second (load_second),
        .tx_enable (tx_enable), .rate_slow (rate_slow),
        .parity_even (parity_even), .line_a (line_a),
        .line_b (line_b), .tx_ready (tx_ready)
    );

    task automatic check(input bit ok, input string tag,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected 32-bit frame from the field positions of R2 and the parity rule of R10.
    function automatic logic [31:0] build_frame(input logic [15:0] h1, h2, input logic even);
        logic [31:0] f;
        f = '0;
        for (int k = 1; k <= 8; k++)   f[k-1] = h1[8-k];
        for (int k = 9; k <= 13; k++)  f[k-1] = h1[k+2];
        for (int k = 14; k <= 29; k++) f[k-1] = h2[k-14];
        f[29] = h1[9];
        f[30] = h1[10];
        if (even) f[31] = ($countones(f[30:0]) % 2) == 1;
        else      f[31] = ($countones(f[30:0]) % 2) == 0;
        return f;
    endfunction

    // Driver: two strobes; an accepted word goes to the scoreboard queue.
    task automatic load_word(input logic [15:0] h1, h2, input bit accept);
        exp_t e;
        @(negedge clk);
        host_data = h1; load_first = 1'b1;
        @(negedge clk);
        load_first = 1'b0; host_data = h2; load_second = 1'b1;
        @(negedge clk);
        load_second = 1'b0;
        if (accept) begin
            e.frame = build_frame(h1, h2, parity_even);
            e.slow  = rate_slow;
            expq.push_back(e);
        end
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!tx_ready);
    endtask

    // Monitor: decodes each word off the line pair and compares it with the queue head.
    initial begin : monitor
        exp_t        e;
        logic [31:0] got;
        int          half, dl, nl, tbad;
        forever begin
            @(negedge clk);
            if (!rst && (line_a || line_b)) begin
                starts.push_back(cyc);
                if (expq.size() > 0) e = expq.pop_front();
                else begin
                    e.frame = '0; e.slow = 1'b0;
                    check(0, "R4 unexpected word on line", 1, 0);
                end
                half = e.slow ? 40 : 5;
                tbad = 0;
                got  = '0;
                for (int i = 0; i < 32; i++) begin
                    got[i] = line_a;
                    dl = 0;
                    while (line_a || line_b) begin dl++; @(negedge clk); end
                    if (dl != half) tbad++;
                    if (i < 31) begin
                        nl = 0;
                        while (!(line_a || line_b)) begin nl++; @(negedge clk); end
                        if (nl != half) tbad++;
                    end
                end
                // R2 R7 R10: decoded frame
                check(got == e.frame, "R2/R10 frame", got, e.frame);
                // R8 R9: per-bit data and null lengths
                check(tbad == 0, "R8/R9 bit timing errors", tbad, 0);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        int s0;
        repeat (4) @(negedge clk);
        // R1: during reset
        check(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1 && !line_a && !line_b, "R1 state after reset",
              {tx_ready, line_a, line_b}, 3'b100);

        // R3: lone second strobe, then lone first strobe
        @(negedge clk); host_data = 16'hFFFF; load_second = 1'b1;
        @(negedge clk); load_second = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R3 lone second strobe", tx_ready, 1);
        host_data = 16'h1234; load_first = 1'b1;
        @(negedge clk); load_first = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_ready == 1'b1, "R3 lone first strobe", tx_ready, 1);

        // R5 R6: one odd-parity word, enable low
        parity_even = 1'b0;
        load_word(16'hA5C3, 16'h0F0F, 1);
        check(tx_ready == 1'b0, "R5 ready falls after commit", tx_ready, 0);
        repeat (50) @(negedge clk);
        check(!line_a && !line_b, "R6 silent while disabled", {line_a, line_b}, 0);
        tx_enable = 1'b1;
        @(negedge clk);
        check(line_a || line_b, "R6 bit 1 next cycle", {line_a, line_b}, 1);
        repeat (319) @(negedge clk);
        check(tx_ready == 1'b0, "R5 ready low before bit 32 null ends", tx_ready, 0);
        @(negedge clk);
        check(tx_ready == 1'b1, "R5 ready high after bit 32 null", tx_ready, 1);
        tx_enable = 1'b0;
        repeat (60) @(negedge clk);

        // R4 R10 R12: fill the queue with even parity, ninth word dropped
        parity_even = 1'b1;
        for (int n = 0; n < 8; n++)
            load_word(16'h1111 * n[15:0] ^ 16'h8421, {n[7:0], 8'h5A} ^ 16'hC003, 1);
        load_word(16'hDEAD, 16'hBEEF, 0);
        check(tx_ready == 1'b0, "R4 ready low while full", tx_ready, 0);
        starts.delete();
        tx_enable = 1'b1;
        wait_ready();
        check(starts.size() == 8, "R4 eight words sent", starts.size(), 8);
        for (int n = 1; n < starts.size(); n++)
            check(starts[n] - starts[n-1] == 360, "R12 fast spacing",
                  starts[n] - starts[n-1], 360);
        tx_enable = 1'b0;
        repeat (60) @(negedge clk);
        check(expq.size() == 0, "R4 queue drained", expq.size(), 0);

        // R9 R12: low-speed pair
        rate_slow = 1'b1; parity_even = 1'b0;
        load_word(16'h00FF, 16'hFFFF, 1);
        load_word(16'hFFFF, 16'h0000, 1);
        starts.delete();
        tx_enable = 1'b1;
        wait_ready();
        check(starts.size() == 2, "R9 two slow words", starts.size(), 2);
        if (starts.size() == 2)
            check(starts[1] - starts[0] == 2880, "R9 slow spacing",
                  starts[1] - starts[0], 2880);
        tx_enable = 1'b0;
        rate_slow = 1'b0;
        repeat (400) @(negedge clk);

        // R11: enable dropped mid-word
        load_word(16'h3C3C, 16'h1234, 1);
        load_word(16'h7777, 16'h8888, 1);
        load_word(16'h0001, 16'h8000, 1);
        starts.delete();
        tx_enable = 1'b1;
        repeat (100) @(negedge clk);
        tx_enable = 1'b0;
        repeat (800) @(negedge clk);
        check(starts.size() == 1, "R11 only current word sent", starts.size(), 1);
        check(expq.size() == 2, "R11 rest held", expq.size(), 2);
        check(tx_ready == 1'b0 && !line_a && !line_b, "R11 idle with words held",
              {tx_ready, line_a, line_b}, 0);
        s0 = cyc;
        tx_enable = 1'b1;
        wait_ready();
        check(expq.size() == 0 && starts.size() == 3, "R11 resume drains",
              starts.size(), 3);
        if (cyc - s0 > 800) check(0, "R11 resume time", cyc - s0, 800);
        tx_enable = 1'b0;
        repeat (20) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule